// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block forms the second operand of a 32-bit data-processing datapath when the shift distance is held in a register rather than encoded in the instruction. It takes an operand, the index of the register that operand came from, an 8-bit distance, a 2-bit shift kind and the current carry flag. It returns the shifted operand and the carry that the shift produces. The block is purely combinational and sits between the register read ports and the ALU.

The distance covers 0 to 255. Distances of the word width and above are handled separately for each shift kind, and each kind has its own result and carry rule there. When the operand register is the program counter (index 15), the operand used is the supplied value plus 4. This accounts for the extra pipeline stage consumed by reading the distance register.

Top module: `bsh_reg_shifter`

## Requirements
- R1: When `opd_idx` is 15, the operand used by every shift kind is `opd_value + 4`, wrapping modulo 2^32. Every other index uses `opd_value` as it is.
- R2: When `shamt` is 0, the result equals the operand and `carry_out` equals `carry_in`, for all four kinds (`shtype` 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right).
- R3: Logical left (`shtype`=00) by n in 1..31 gives the operand shifted left with zero fill. `carry_out` is operand bit 32-n.
- R4: Logical left (00) by exactly 32 gives 0 with `carry_out` equal to operand bit 0. By 33..255 it gives 0 with `carry_out` 0.
- R5: Logical right (`shtype`=01) by n in 1..31 gives the operand shifted right with zero fill. `carry_out` is operand bit n-1.
- R6: Logical right (01) by exactly 32 gives 0 with `carry_out` equal to operand bit 31. By 33..255 it gives 0 with `carry_out` 0.
- R7: Arithmetic right (`shtype`=10) by n in 1..31 fills with operand bit 31. `carry_out` is operand bit n-1.
- R8: Arithmetic right (10) by 32..255 gives all ones with `carry_out` 1 when operand bit 31 is set. Otherwise it gives 0 with `carry_out` 0.
- R9: Rotate right (`shtype`=11) uses m = `shamt` mod 32. When m is nonzero, the result is the operand rotated right by m and `carry_out` is operand bit m-1.
- R10: Rotate right (11) by a nonzero multiple of 32 (32, 64, ..., 224) returns the operand unchanged with `carry_out` equal to operand bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_value | input | 32 | Operand read from the register file (raw program counter when index is 15) |
| opd_idx | input | 4 | Register index the operand was read from |
| shamt | input | 8 | Shift distance, low byte of the distance register |
| shtype | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| carry_in | input | 1 | Current carry flag |
| res | output | 32 | Shifted operand |
| carry_out | output | 1 | Carry produced by the shift |

## Verification
The bench builds the block with its default parameters: a 32-bit word, an 8-bit distance and a 4-bit register index with 15 as the program counter. With an 8-bit distance the full range 0..255 is small enough to sweep exhaustively for every shift kind. Every exact-width and above-width rule, and every rotate multiple of 32, is therefore reached directly rather than sampled. The 4-bit index reaches the program-counter case, and an operand near 2^32 exercises the wrap of the +4 adjustment.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/bsh_operand_sel.sv
module bsh_operand_sel #(
  parameter int WIDTH     = 32,
  parameter int IDX_W     = 4,
  parameter int PC_IDX    = 15,
  parameter int PC_OFFSET = 4
) (
  input  logic [WIDTH-1:0] raw_val,
  input  logic [IDX_W-1:0] raw_idx,
  output logic [WIDTH-1:0] eff_val
);
  localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_IDX);
  localparam logic [WIDTH-1:0] PC_ADD  = WIDTH'(PC_OFFSET);

  always_comb begin
    if (raw_idx == PC_CODE) eff_val = raw_val + PC_ADD;
    else                    eff_val = raw_val;
  end
endmodule

// File: rtl/bsh_amount_class.sv
module bsh_amount_class #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [AMT_W-1:0]         amt,
  output logic [$clog2(WIDTH)-1:0] amt_low,
  output logic                     amt_zero,
  output logic                     amt_inside,
  output logic                     amt_exact,
  output logic                     amt_beyond
);
  localparam int LOG2 = $clog2(WIDTH);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

  always_comb begin
    amt_low    = amt[LOG2-1:0];
    amt_zero   = (amt == '0);
    amt_inside = !amt_zero && (amt < W_AMT);
    amt_exact  = (amt == W_AMT);
    amt_beyond = (amt > W_AMT);
  end
endmodule

// File: rtl/bsh_shift_unit.sv
module bsh_shift_unit
  import bsh_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         op,
  input  shift_kind_e              kind,
  input  logic                     cin,
  input  logic [$clog2(WIDTH)-1:0] lw,
  input  logic                     amt_zero,
  input  logic                     amt_inside,
  input  logic                     amt_exact,
  output logic [WIDTH-1:0]         val,
  output logic                     cout
);
  logic [WIDTH:0]          lsl_x;
  logic [WIDTH:0]          lsr_x;
  logic [WIDTH:0]          asr_x;
  logic [2*WIDTH-1:0]      ror_x;
  logic                    msb;

  always_comb begin
    msb   = op[WIDTH-1];
    lsl_x = {1'b0, op} << lw;
    lsr_x = {op, 1'b0} >> lw;
    asr_x = $signed({op, 1'b0}) >>> lw;
    ror_x = {op, op} >> lw;
  end

  always_comb begin
    val  = op;
    cout = cin;
    if (!amt_zero) begin
      unique case (kind)
        SH_LSL: begin
          if (amt_inside) begin
            val  = lsl_x[WIDTH-1:0];
            cout = lsl_x[WIDTH];
          end else begin
            val  = '0;
            cout = amt_exact & op[0];
          end
        end
        SH_LSR: begin
          if (amt_inside) begin
            val  = lsr_x[WIDTH:1];
            cout = lsr_x[0];
          end else begin
            val  = '0;
            cout = amt_exact & msb;
          end
        end
        SH_ASR: begin
          if (amt_inside) begin
            val  = asr_x[WIDTH:1];
            cout = asr_x[0];
          end else begin
            val  = {WIDTH{msb}};
            cout = msb;
          end
        end
        default: begin
          val  = ror_x[WIDTH-1:0];
          cout = ror_x[WIDTH-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/bsh_reg_shifter.sv
module bsh_reg_shifter
  import bsh_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int AMT_W     = 8,
  parameter int IDX_W     = 4,
  parameter int PC_IDX    = 15,
  parameter int PC_OFFSET = 4
) (
  input  logic [WIDTH-1:0] opd_value,
  input  logic [IDX_W-1:0] opd_idx,
  input  logic [AMT_W-1:0] shamt,
  input  logic [1:0]       shtype,
  input  logic             carry_in,
  output logic [WIDTH-1:0] res,
  output logic             carry_out
);
  localparam int LOG2 = $clog2(WIDTH);

  logic [WIDTH-1:0] eff_op;
  logic [LOG2-1:0]  low_amt;
  logic             is_zero;
  logic             is_inside;
  logic             is_exact;
  logic             is_beyond;

  bsh_operand_sel #(
    .WIDTH(WIDTH), .IDX_W(IDX_W), .PC_IDX(PC_IDX), .PC_OFFSET(PC_OFFSET)
  ) u_opsel (
    .raw_val(opd_value),
    .raw_idx(opd_idx),
    .eff_val(eff_op)
  );

  bsh_amount_class #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_amt (
    .amt       (shamt),
    .amt_low   (low_amt),
    .amt_zero  (is_zero),
    .amt_inside(is_inside),
    .amt_exact (is_exact),
    .amt_beyond(is_beyond)
  );

  bsh_shift_unit #(.WIDTH(WIDTH)) u_shift (
    .op        (eff_op),
    .kind      (shift_kind_e'(shtype)),
    .cin       (carry_in),
    .lw        (low_amt),
    .amt_zero  (is_zero),
    .amt_inside(is_inside),
    .amt_exact (is_exact),
    .val       (res),
    .cout      (carry_out)
  );
endmodule

// File: rtl/bsh_reg_shifter_chk.sv
module bsh_reg_shifter_chk #(
  parameter int WIDTH     = 32,
  parameter int AMT_W     = 8,
  parameter int IDX_W     = 4,
  parameter int PC_IDX    = 15,
  parameter int PC_OFFSET = 4
) (
  input logic [WIDTH-1:0] opd_value,
  input logic [IDX_W-1:0] opd_idx,
  input logic [AMT_W-1:0] shamt,
  input logic [1:0]       shtype,
  input logic             carry_in,
  input logic [WIDTH-1:0] res,
  input logic             carry_out
);
  localparam int LOG2 = $clog2(WIDTH);
  logic [WIDTH-1:0] op_seen;
  logic             top;

  always_comb begin
    op_seen = (opd_idx == IDX_W'(PC_IDX)) ? opd_value + WIDTH'(PC_OFFSET) : opd_value;
    top     = op_seen[WIDTH-1];
    if (shamt == '0)
      AST_ZERO_PASS: assert (res == op_seen && carry_out == carry_in); // R2
    if (shtype == 2'b00 && shamt > AMT_W'(WIDTH))
      AST_LSL_BEYOND: assert (res == '0 && !carry_out); // R4
    if (shtype == 2'b01 && shamt > AMT_W'(WIDTH))
      AST_LSR_BEYOND: assert (res == '0 && !carry_out); // R6
    if (shtype == 2'b01 && shamt != '0 && shamt < AMT_W'(WIDTH))
      AST_LSR_TOP_CLEAR: assert (!res[WIDTH-1]); // R5
    if (shtype == 2'b10 && shamt != '0 && shamt < AMT_W'(WIDTH))
      AST_ASR_SIGN_KEPT: assert (res[WIDTH-1] == top); // R7
    if (shtype == 2'b10 && shamt >= AMT_W'(WIDTH))
      AST_ASR_SATURATE: assert (res == {WIDTH{top}} && carry_out == top); // R8
    if (shtype == 2'b11 && shamt != '0 && shamt[LOG2-1:0] == '0)
      AST_ROR_WHOLE_TURN: assert (res == op_seen && carry_out == top); // R10
  end
endmodule

bind bsh_reg_shifter bsh_reg_shifter_chk #(
  .WIDTH(WIDTH), .AMT_W(AMT_W), .IDX_W(IDX_W), .PC_IDX(PC_IDX), .PC_OFFSET(PC_OFFSET)
) u_chk (
  .opd_value(opd_value),
  .opd_idx  (opd_idx),
  .shamt    (shamt),
  .shtype   (shtype),
  .carry_in (carry_in),
  .res      (res),
  .carry_out(carry_out)
);

// File: tb/tb_bsh_reg_shifter.sv
module tb_bsh_reg_shifter;
  logic        clk;
  logic [31:0] opd_value;
  logic [3:0]  opd_idx;
  logic [7:0]  shamt;
  logic [1:0]  shtype;
  logic        carry_in;
  logic [31:0] res;
  logic        carry_out;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 0;

  bsh_reg_shifter dut (
    .opd_value(opd_value), .opd_idx(opd_idx), .shamt(shamt),
    .shtype(shtype), .carry_in(carry_in), .res(res), .carry_out(carry_out)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Reference: returns {carry, value}
  function automatic logic [32:0] model(input logic [31:0] v, input logic [3:0] idx,
                                        input int n, input int kind, input logic ci);
    logic [31:0] e;
    int m;
    e = (idx == 4'd15) ? v + 32'd4 : v;
    case (kind)
      0: if (n == 0) return {ci, e};
         else if (n < 32) return {e[32-n], e << n};
         else if (n == 32) return {e[0], 32'd0};
         else return 33'd0;
      1: if (n == 0) return {ci, e};
         else if (n < 32) return {e[n-1], e >> n};
         else if (n == 32) return {e[31], 32'd0};
         else return 33'd0;
      2: if (n == 0) return {ci, e};
         else if (n < 32) return {e[n-1], 32'($signed(e) >>> n)};
         else return {e[31], {32{e[31]}}};
      default: begin
        m = n % 32;
        if (n == 0) return {ci, e};
        else if (m != 0) return {e[m-1], (e >> m) | (e << (32 - m))};
        else return {e[31], e};
      end
    endcase
  endfunction

  function automatic string tag_of(input int n, input int kind, input logic [3:0] idx);
    if (idx == 4'd15 && n != 0) return "R1";
    if (n == 0) return "R2";
    case (kind)
      0: return (n < 32) ? "R3" : "R4";
      1: return (n < 32) ? "R5" : "R6";
      2: return (n < 32) ? "R7" : "R8";
      default: return (n % 32 != 0) ? "R9" : "R10";
    endcase
  endfunction

  task automatic apply_check(input logic [31:0] v, input logic [3:0] idx, input int n,
                             input int kind, input logic ci, input string tag);
    logic [32:0] exp;
    opd_value = v; opd_idx = idx; shamt = 8'(n); shtype = 2'(kind); carry_in = ci;
    #1;
    exp = model(v, idx, n, kind, ci);
    total++;
    if ({carry_out, res} !== exp) begin
      bad++;
      $display("FAIL %s kind=%0d amt=%0d op=%h: got c=%b v=%h, expected c=%b v=%h",
               tag, kind, n, v, carry_out, res, exp[32], exp[31:0]);
    end
  endtask

  task automatic t_idle;
    apply_check(32'h0, 4'd0, 0, 0, 1'b0, "R2");
  endtask

  task automatic t_zero_amount; // R2
    for (int k = 0; k < 4; k++) begin
      apply_check(32'hDEAD_BEEF, 4'd3, 0, k, 1'b1, "R2");
      apply_check(32'h1234_5678, 4'd7, 0, k, 1'b0, "R2");
    end
  endtask

  task automatic t_pc_operand; // R1
    apply_check(32'h0000_1000, 4'd15, 0, 0, 1'b0, "R1");
    apply_check(32'hFFFF_FFFE, 4'd15, 0, 1, 1'b1, "R1");
    apply_check(32'hFFFF_FFFC, 4'd15, 32, 0, 1'b0, "R1");
    apply_check(32'h8000_0000, 4'd15, 4, 3, 1'b0, "R1");
    apply_check(32'h0000_1000, 4'd14, 0, 0, 1'b0, "R1");
  endtask

  task automatic sweep_kind(input int kind);
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = $urandom;
    pats[3] = $urandom | 32'h8000_0000;
    for (int n = 0; n < 256; n++)
      for (int p = 0; p < 4; p++)
        apply_check(pats[p], (p == 3) ? 4'd15 : 4'd2, n, kind, n[0],
                    tag_of(n, kind, (p == 3) ? 4'd15 : 4'd2));
  endtask

  task automatic t_lsl; sweep_kind(0); endtask  // R3 R4
  task automatic t_lsr; sweep_kind(1); endtask  // R5 R6
  task automatic t_asr; sweep_kind(2); endtask  // R7 R8
  task automatic t_ror; // R9 R10
    sweep_kind(3);
    apply_check(32'h8000_0000, 4'd0, 64, 3, 1'b0, "R10");
    apply_check(32'h0000_0001, 4'd0, 224, 3, 1'b1, "R10");
    apply_check(32'h0000_0003, 4'd0, 33, 3, 1'b0, "R9");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    opd_value = '0; opd_idx = '0; shamt = '0; shtype = '0; carry_in = 1'b0;
    @(negedge clk);
    t_idle();
    t_zero_amount();
    t_pc_operand();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule